// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block watches each processor bus cycle and raises a bus error when a cycle runs too long without being acknowledged. A cycle is in progress while the address strobe is high. While the monitor is enabled, it counts the clock cycles of the strobe. If the count reaches the timeout limit before data acknowledge arrives, the bus error output goes high. It then stays high until the strobe falls.

A write-protect violation reported during a strobe also raises the bus error. The violation is routed into the same sticky status flag. A small control/status register holds an enable bit and that flag. Software reads the register to find the cause of a bus error exception and writes a one to the flag to clear it. The block does not decode addresses and does not perform the transfer itself.

Top module: `bus_timeout_monitor`

## Requirements
- R1: After reset the bus error output is low and the register reads 0x01: enable (bit 0) is 1 and the timeout flag (bit 1) is 0. All other register bits read 0.
- R2: While enabled, the monitor counts every clock edge at which the strobe is high and no acknowledge has been seen. The bus error output rises at the edge where the 128th such cycle is counted (TIMEOUT_CYCLES = 128), and not one edge earlier.
- R3: Once high, the bus error output stays high for as long as the strobe stays high. It falls at the first clock edge at which the strobe is sampled low.
- R4: If acknowledge is sampled high during a cycle before the error fires, that cycle produces no bus error, however long the strobe then stays high. This includes an acknowledge at the same edge as the 128th count.
- R5: The count starts again from zero at every new strobe. Two back-to-back strobes of 100 cycles each, separated by one low cycle, produce no bus error.
- R6: Every timeout sets the flag (register bit 1) at the same edge at which the bus error rises. The flag then stays set.
- R7: A register write with bit 1 set clears the flag, and a write with bit 1 clear leaves it unchanged. If a set event and a clearing write happen at the same edge, the set wins.
- R8: A write-protect violation sampled while the strobe is high raises the bus error at that edge and sets the flag, whether the monitor is enabled or not. A violation sampled while the strobe is low has no effect.
- R9: Clearing the enable bit during a strobe stops the counting, so no timeout occurs in that cycle. It does not release a bus error that is already high; that error falls only when the strobe falls.
- R10: A register write loads the enable bit from bit 1's neighbour, bit 0, and the new value can be read back at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_strobe | input | 1 | Address strobe, high while a bus cycle is in progress |
| cyc_ack | input | 1 | Data acknowledge for the current cycle |
| wp_violation | input | 1 | Write-protect violation for the current cycle |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | REG_W | Register write data |
| csr_rdata | output | REG_W | Register readback: bit 0 enable, bit 1 timeout flag |
| bus_err | output | 1 | Bus error, held until the strobe falls |

## Verification
On every cycle the assertions check four things:
- the error falls after the strobe is sampled low, and is held while the strobe stays high;
- every rise of the error comes with the flag set, and the flag never drops except after a clearing write;
- an acknowledged or disabled cycle with no violation raises no error;
- a violation during a strobe raises the error.

The bench's scenarios cover the timing and the register behaviour:
- the exact edge of the timeout, and acknowledge arriving at the 128th cycle;
- the restart of the count between strobes;
- the write-one-to-clear encoding, and the set-over-clear priority.

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor #(
  parameter int TIMEOUT_CYCLES = 128,
  parameter int REG_W          = 8,
  parameter int EN_BIT         = 0,
  parameter int FLAG_BIT       = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_strobe,
  input  logic             cyc_ack,
  input  logic             wp_violation,
  input  logic             csr_we,
  input  logic [REG_W-1:0] csr_wdata,
  output logic [REG_W-1:0] csr_rdata,
  output logic             bus_err
);

  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic             enable;
  logic             flag;
  logic             acked;
  logic [CNT_W-1:0] count;

  logic counting, timeout, wp_hit, err_set, flag_clr;

  assign counting = cyc_strobe && enable && !acked && !cyc_ack && !bus_err;
  assign timeout  = counting && (count == LAST);
  assign wp_hit   = cyc_strobe && wp_violation;
  assign err_set  = timeout || wp_hit;
  assign flag_clr = csr_we && csr_wdata[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      acked <= 1'b0;
    end else if (!cyc_strobe) begin
      count <= '0;
      acked <= 1'b0;
    end else begin
      if (cyc_ack) acked <= 1'b1;
      if (counting) count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bus_err <= 1'b0;
    else if (!cyc_strobe) bus_err <= 1'b0;
    else if (err_set)     bus_err <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b1;
      flag   <= 1'b0;
    end else begin
      if (csr_we)        enable <= csr_wdata[EN_BIT];
      if (err_set)       flag   <= 1'b1;
      else if (flag_clr) flag   <= 1'b0;
    end
  end

  always_comb begin
    csr_rdata           = '0;
    csr_rdata[EN_BIT]   = enable;
    csr_rdata[FLAG_BIT] = flag;
  end

endmodule

module bus_timeout_monitor_checks #(
  parameter int REG_W    = 8,
  parameter int FLAG_BIT = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_strobe,
  input logic             cyc_ack,
  input logic             wp_violation,
  input logic             csr_we,
  input logic [REG_W-1:0] csr_wdata,
  input logic             enable,
  input logic             flag,
  input logic             bus_err
);

  assert_release_on_strobe_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_strobe |=> !bus_err);

  assert_hold_while_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && cyc_strobe) |=> bus_err);

  assert_err_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> flag);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(csr_we && csr_wdata[FLAG_BIT])) |=> flag);

  assert_ack_blocks_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ack && !bus_err && !wp_violation) |=> !bus_err);

  assert_disabled_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !bus_err && !wp_violation) |=> !bus_err);

  assert_wp_raises_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_strobe && wp_violation) |=> (bus_err && flag));

endmodule

bind bus_timeout_monitor bus_timeout_monitor_checks #(
  .REG_W(REG_W), .FLAG_BIT(FLAG_BIT)
) u_checks (
  .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .cyc_ack(cyc_ack),
  .wp_violation(wp_violation), .csr_we(csr_we), .csr_wdata(csr_wdata),
  .enable(enable), .flag(flag), .bus_err(bus_err)
);

// File: tb/test_bus_timeout_monitor.sv
module test_bus_timeout_monitor;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_strobe = 1'b0;
  logic       cyc_ack = 1'b0;
  logic       wp_violation = 1'b0;
  logic       csr_we = 1'b0;
  logic [7:0] csr_wdata = '0;
  logic [7:0] csr_rdata;
  logic       bus_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  bus_timeout_monitor i_bus_timeout_monitor (
    .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .cyc_ack(cyc_ack),
    .wp_violation(wp_violation), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .bus_err(bus_err)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] d);
    csr_we = 1'b1; csr_wdata = d;
    tick(1);
    csr_we = 1'b0; csr_wdata = '0;
  endtask

  task automatic end_cycle;
    cyc_strobe = 1'b0; cyc_ack = 1'b0; wp_violation = 1'b0;
    tick(2);
  endtask

  task automatic test_reset_r1;
    check("R1 bus_err", {7'b0, bus_err}, 8'h00);
    check("R1 rdata", csr_rdata, 8'h01);
  endtask

  task automatic test_timeout_r2_r3_r6;
    cyc_strobe = 1'b1;
    tick(127);
    check("R2 no error at 127", {7'b0, bus_err}, 8'h00);
    check("R6 flag clear before timeout", csr_rdata, 8'h01);
    tick(1);
    check("R2 error at 128", {7'b0, bus_err}, 8'h01);
    check("R6 flag set", csr_rdata, 8'h03);
    tick(5);
    check("R3 error held", {7'b0, bus_err}, 8'h01);
    cyc_strobe = 1'b0;
    #0.5;
    check("R3 held until edge", {7'b0, bus_err}, 8'h01);
    tick(1);
    check("R3 released", {7'b0, bus_err}, 8'h00);
    check("R6 flag sticky", csr_rdata, 8'h03);
    tick(1);
  endtask

  task automatic test_w1c_r7;
    reg_write(8'h01);
    check("R7 write zero keeps flag", csr_rdata, 8'h03);
    reg_write(8'h03);
    check("R7 write one clears flag", csr_rdata, 8'h01);
    cyc_strobe = 1'b1; wp_violation = 1'b1;
    csr_we = 1'b1; csr_wdata = 8'h03;
    tick(1);
    csr_we = 1'b0; csr_wdata = '0;
    check("R7 set wins over clear", csr_rdata, 8'h03);
    end_cycle();
    reg_write(8'h03);
    check("R7 cleared again", csr_rdata, 8'h01);
  endtask

  task automatic test_ack_r4;
    cyc_strobe = 1'b1;
    tick(50);
    cyc_ack = 1'b1;
    tick(1);
    cyc_ack = 1'b0;
    tick(200);
    check("R4 early ack no error", {7'b0, bus_err}, 8'h00);
    end_cycle();
    cyc_strobe = 1'b1;
    tick(127);
    cyc_ack = 1'b1;
    tick(1);
    check("R4 ack at 128 no error", {7'b0, bus_err}, 8'h00);
    cyc_ack = 1'b0;
    tick(100);
    check("R4 ack at 128 stays clear", {7'b0, bus_err}, 8'h00);
    check("R4 flag untouched", csr_rdata, 8'h01);
    end_cycle();
  endtask

  task automatic test_restart_r5;
    cyc_strobe = 1'b1;
    tick(100);
    cyc_strobe = 1'b0;
    tick(1);
    cyc_strobe = 1'b1;
    tick(100);
    check("R5 no accumulation", {7'b0, bus_err}, 8'h00);
    end_cycle();
  endtask

  task automatic test_disable_r9_r10;
    cyc_strobe = 1'b1;
    tick(60);
    reg_write(8'h00);
    check("R10 enable cleared", csr_rdata, 8'h00);
    tick(200);
    check("R9 disabled no timeout", {7'b0, bus_err}, 8'h00);
    end_cycle();
    reg_write(8'h01);
    check("R10 enable set", csr_rdata, 8'h01);
    cyc_strobe = 1'b1;
    tick(128);
    check("R9 timeout before disable", {7'b0, bus_err}, 8'h01);
    reg_write(8'h00);
    tick(3);
    check("R9 disable keeps error", {7'b0, bus_err}, 8'h01);
    end_cycle();
    check("R9 released by strobe", {7'b0, bus_err}, 8'h00);
  endtask

  task automatic test_wp_r8;
    reg_write(8'h02);
    check("R8 disabled and flag clear", csr_rdata, 8'h00);
    wp_violation = 1'b1;
    tick(2);
    check("R8 no strobe no error", {7'b0, bus_err}, 8'h00);
    check("R8 no strobe no flag", csr_rdata, 8'h00);
    cyc_strobe = 1'b1;
    tick(1);
    check("R8 violation raises error", {7'b0, bus_err}, 8'h01);
    check("R8 violation sets flag", csr_rdata, 8'h02);
    end_cycle();
    reg_write(8'h03);
  endtask

  initial begin
    fork
      begin
        tick(100000);
        if (!done) begin
          n_tests++; n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
          $finish;
        end
      end
    join_none
    #5 rst_n = 1'b1;
    tick(1);
    test_reset_r1();
    test_timeout_r2_r3_r6();
    test_w1c_r7();
    test_ack_r4();
    test_restart_r5();
    test_disable_r9_r10();
    test_wp_r8();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule